// File: doc/BRIEF.md
# Frame-Locked Fractional Bit-Clock Divider

This block turns a parallel-port receive clock into the 4.096 MHz bit clock used by the serial side. It also produces a one-tick serial frame marker derived from that clock. The receive clock may run at 16.384 MHz or at 19.44 MHz. For the lower rate the division is an exact divide-by-4. For the higher rate the ratio is not an integer: the block spreads 512 output periods over the 2430 input periods of a 125 µs frame. It does this by letting each output transition land on either a rising or a falling input edge.

Both input edges are modelled as one-cycle ticks of a design clock running at twice the receive rate, so every register sits in one synchronous domain. A phase accumulator chooses the ticks on which the output level flips. Each receive frame pulse clears the accumulator and forces the output high. This keeps the serial timing slaved to the parallel framing. Between pulses the divider and the frame marker run freely.

An enable input chooses the clock source. When the enable is clear, the bit clock is taken from an external pin and the generated outputs stay low. When it is set, the divider drives the bit clock.

Top module: `frac_clk_div`

## Requirements
- R1: While `rst` is high at a clock edge, the next sample shows `bclk_out` = 0 and `frame_out` = 0. The active ratio returns to the divide-by-4 setting.
- R2: With `div_en` = 0, `bit_clk` follows `ext_bclk`. One tick after `div_en` is seen low, `bclk_out` and `frame_out` are 0. A frame pulse applied while `div_en` = 0 has no effect.
- R3: With `div_en` = 1, `bit_clk` equals `bclk_out`.
- R4: With the ratio setting `mode_sel` = 0 active, `bclk_out` flips every 4 ticks, so one output period is 8 ticks. A 4096-tick frame holds exactly 1024 flips.
- R5: With the ratio setting `mode_sel` = 1 active, let k be the number of ticks since the phase anchor. `bclk_out` flips on each tick where floor(1024·k / 4860) increases. Flips are therefore 4 or 5 ticks apart, and a 4860-tick frame holds exactly 1024 flips.
- R6: A tick with `div_en` = 1 and `frm_pulse` = 1 realigns the divider. On the next sample `bclk_out` = 1 and `frame_out` = 1, and the pattern restarts from k = 0 with the level high.
- R7: Without further pulses, `frame_out` is high for one tick every L ticks after the last realign or restart. L is 4096 for `mode_sel` = 0 and 4860 for `mode_sel` = 1.
- R8: A change of `mode_sel` takes effect only at the next realigning frame pulse. Until then the previously latched ratio stays in use.
- R9: After `div_en` goes from 0 to 1, the divider starts free-running from a cleared state: level low, k = 0, and no frame marker until L ticks have elapsed. It keeps the ratio latched before the disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate design clock; each cycle is one receive-clock half period |
| rst | input | 1 | Synchronous active-high reset |
| div_en | input | 1 | 1 = divider drives the bit clock, 0 = external bit clock used |
| mode_sel | input | 1 | Ratio request: 0 = divide-by-4, 1 = 1024/4860 fractional |
| frm_pulse | input | 1 | Receive frame pulse, one tick wide |
| ext_bclk | input | 1 | Externally supplied bit clock |
| bit_clk | output | 1 | Bit clock in use by the serial side |
| bclk_out | output | 1 | Generated bit clock output copy |
| frame_out | output | 1 | Serial frame marker, one tick wide |

## Verification
The divider is driven with regular frame pulses in both ratio settings. Counting output flips per frame separates an exact 1024/4860 spread from a rounded integer divide. A long stretch without pulses separates free-running frame markers from markers that only echo the input pulse. An early, off-schedule pulse shows whether realignment is immediate. Changing the ratio request without a pulse, and toggling the enable with pulses applied while it is disabled, show whether the ratio latch and the cleared restart behave as required.

// File: rtl/frac_clk_div_pkg.sv
package frac_clk_div_pkg;

    localparam int RATIO_W = 16;

    typedef logic [RATIO_W-1:0] ratio_word_t;

    typedef enum logic {
        RATIO_INT  = 1'b0,
        RATIO_FINE = 1'b1
    } ratio_e;

    typedef struct packed {
        ratio_word_t step;
        ratio_word_t modulus;
        ratio_word_t frame_len;
    } ratio_t;

    typedef struct packed {
        logic        level;
        ratio_word_t acc;
    } phase_t;

    typedef struct packed {
        logic        mark;
        ratio_word_t count;
    } frame_t;

    function automatic ratio_t make_ratio(input int s, input int m, input int f);
        ratio_t r;
        r.step      = ratio_word_t'(s);
        r.modulus   = ratio_word_t'(m);
        r.frame_len = ratio_word_t'(f);
        return r;
    endfunction

    function automatic ratio_t pick_ratio(input ratio_e sel, input ratio_t int_r, input ratio_t fine_r);
        return (sel == RATIO_FINE) ? fine_r : int_r;
    endfunction

endpackage

// File: rtl/fcd_mode_latch.sv
module fcd_mode_latch
    import frac_clk_div_pkg::*;
#(
    parameter int INT_STEP   = 1,
    parameter int INT_MOD    = 4,
    parameter int INT_FRAME  = 4096,
    parameter int FINE_STEP  = 1024,
    parameter int FINE_MOD   = 4860,
    parameter int FINE_FRAME = 4860
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        realign,
    input  logic        mode_sel,
    output ratio_e      mode_q,
    output ratio_word_t step,
    output ratio_word_t modulus,
    output ratio_word_t frame_len
);

    localparam ratio_t INT_R  = make_ratio(INT_STEP, INT_MOD, INT_FRAME);
    localparam ratio_t FINE_R = make_ratio(FINE_STEP, FINE_MOD, FINE_FRAME);

    ratio_t active;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= RATIO_INT;
        end else if (realign) begin
            mode_q <= ratio_e'(mode_sel);
        end
    end

    always_comb begin
        active    = pick_ratio(mode_q, INT_R, FINE_R);
        step      = active.step;
        modulus   = active.modulus;
        frame_len = active.frame_len;
    end

endmodule

// File: rtl/fcd_phase_acc.sv
module fcd_phase_acc
    import frac_clk_div_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic        realign,
    input  ratio_word_t step,
    input  ratio_word_t modulus,
    output logic        level
);

    localparam int SUM_W = RATIO_W + 1;

    phase_t           st_q;
    phase_t           st_d;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] mod_ext;
    logic             wrap;

    always_comb begin
        sum     = {1'b0, st_q.acc} + {1'b0, step};
        mod_ext = {1'b0, modulus};
        wrap    = (sum >= mod_ext);
        st_d    = st_q;
        if (!en) begin
            st_d = '0;
        end else if (realign) begin
            st_d.acc   = '0;
            st_d.level = 1'b1;
        end else begin
            st_d.acc = wrap ? ratio_word_t'(sum - mod_ext) : ratio_word_t'(sum);
            if (wrap) begin
                st_d.level = ~st_q.level;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.level;

endmodule

// File: rtl/fcd_frame_ctr.sv
module fcd_frame_ctr
    import frac_clk_div_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic        realign,
    input  ratio_word_t frame_len,
    output logic        mark
);

    frame_t      fr_q;
    frame_t      fr_d;
    ratio_word_t last_idx;

    always_comb begin
        last_idx = frame_len - ratio_word_t'(1);
        fr_d     = fr_q;
        if (!en) begin
            fr_d = '0;
        end else if (realign) begin
            fr_d.count = '0;
            fr_d.mark  = 1'b1;
        end else if (fr_q.count >= last_idx) begin
            fr_d.count = '0;
            fr_d.mark  = 1'b1;
        end else begin
            fr_d.count = fr_q.count + ratio_word_t'(1);
            fr_d.mark  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fr_q <= '0;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign mark = fr_q.mark;

endmodule

// File: rtl/fcd_clk_sel.sv
module fcd_clk_sel (
    input  logic div_en,
    input  logic gen_clk,
    input  logic ext_clk,
    output logic sel_clk
);

    always_comb begin
        sel_clk = div_en ? gen_clk : ext_clk;
    end

endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
    import frac_clk_div_pkg::*;
#(
    parameter int INT_STEP   = 1,
    parameter int INT_MOD    = 4,
    parameter int INT_FRAME  = 4096,
    parameter int FINE_STEP  = 1024,
    parameter int FINE_MOD   = 4860,
    parameter int FINE_FRAME = 4860
) (
    input  logic clk,
    input  logic rst,
    input  logic div_en,
    input  logic mode_sel,
    input  logic frm_pulse,
    input  logic ext_bclk,
    output logic bit_clk,
    output logic bclk_out,
    output logic frame_out
);

    ratio_e      mode_act;
    ratio_word_t step;
    ratio_word_t modulus;
    ratio_word_t frame_len;
    logic        realign;

    assign realign = div_en & frm_pulse;

    fcd_mode_latch #(
        .INT_STEP  (INT_STEP),
        .INT_MOD   (INT_MOD),
        .INT_FRAME (INT_FRAME),
        .FINE_STEP (FINE_STEP),
        .FINE_MOD  (FINE_MOD),
        .FINE_FRAME(FINE_FRAME)
    ) u_mode (
        .clk      (clk),
        .rst      (rst),
        .realign  (realign),
        .mode_sel (mode_sel),
        .mode_q   (mode_act),
        .step     (step),
        .modulus  (modulus),
        .frame_len(frame_len)
    );

    fcd_phase_acc u_phase (
        .clk    (clk),
        .rst    (rst),
        .en     (div_en),
        .realign(realign),
        .step   (step),
        .modulus(modulus),
        .level  (bclk_out)
    );

    fcd_frame_ctr u_frame (
        .clk      (clk),
        .rst      (rst),
        .en       (div_en),
        .realign  (realign),
        .frame_len(frame_len),
        .mark     (frame_out)
    );

    fcd_clk_sel u_sel (
        .div_en (div_en),
        .gen_clk(bclk_out),
        .ext_clk(ext_bclk),
        .sel_clk(bit_clk)
    );

endmodule

// File: rtl/frac_clk_div_chk.sv
module frac_clk_div_chk
    import frac_clk_div_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   div_en,
    input logic   frm_pulse,
    input logic   bclk_out,
    input logic   frame_out,
    input ratio_e mode_act
);

    logic primed;

    always_ff @(posedge clk) begin
        if (rst) begin
            primed <= 1'b0;
        end else begin
            primed <= 1'b1;
        end
    end

    // R2: disabled divider leaves its outputs low
    assert_idle_outputs_R2: assert property (@(posedge clk) disable iff (rst)
        !div_en |=> (!bclk_out && !frame_out));

    // R6: a frame pulse forces the high phase and a frame marker
    assert_realign_R6: assert property (@(posedge clk) disable iff (rst)
        (div_en && frm_pulse) |=> (bclk_out && frame_out));

    // R7: free-running frame marker lasts one tick
    assert_single_mark_R7: assert property (@(posedge clk) disable iff (rst)
        (div_en && frame_out && !frm_pulse) |=> !frame_out);

    // R5 (and R4): no two flips on adjacent ticks
    assert_min_spacing_R5: assert property (@(posedge clk) disable iff (rst)
        (primed && div_en && !frm_pulse && $past(div_en) && !$past(frm_pulse)
         && (bclk_out != $past(bclk_out))) |=> $stable(bclk_out));

    // R8: latched ratio changes only after a realigning pulse
    assert_mode_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (primed && !$stable(mode_act)) |-> $past(div_en && frm_pulse));

endmodule

bind frac_clk_div frac_clk_div_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .div_en   (div_en),
    .frm_pulse(frm_pulse),
    .bclk_out (bclk_out),
    .frame_out(frame_out),
    .mode_act (mode_act)
);

// File: tb/frac_clk_div_tb.sv
`timescale 1ns/1ps
module frac_clk_div_tb;

    localparam int IS = 1;
    localparam int IM = 4;
    localparam int IL = 4096;
    localparam int FS = 1024;
    localparam int FM = 4860;
    localparam int FL = 4860;

    logic clk = 1'b0;
    logic rst, div_en, mode_sel, frm_pulse, ext_bclk;
    logic bit_clk, bclk_out, frame_out;

    always #2.5 clk = ~clk;

    frac_clk_div u_dut (
        .clk(clk), .rst(rst), .div_en(div_en), .mode_sel(mode_sel),
        .frm_pulse(frm_pulse), .ext_bclk(ext_bclk),
        .bit_clk(bit_clk), .bclk_out(bclk_out), .frame_out(frame_out)
    );

    int      vectors = 0;
    int      miscompares = 0;
    string   ctx = "R1 reset";
    longint  k = 0;
    bit      ph = 0;
    bit      pul = 0;
    int      m_mode = 0;
    int      gtick = 0;
    int      toggles = 0;
    int      frames = 0;
    logic    last_bclk = 1'b0;
    bit      done = 0;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic compare();
        longint st, md, ln;
        bit exp_b, exp_f, exp_c, bad;
        string tb_tag;
        st = (m_mode != 0) ? FS : IS;
        md = (m_mode != 0) ? FM : IM;
        ln = (m_mode != 0) ? FL : IL;
        exp_b = ph ^ bit'(((st * k) / md) % 2);
        exp_f = (k == 0) ? pul : ((k % ln) == 0);
        exp_c = div_en ? exp_b : ext_bclk;
        tb_tag = (k == 0 && pul) ? "R6" : ((m_mode != 0) ? "R5" : "R4");
        bad = 0;
        vectors++;
        if (bclk_out !== exp_b) begin
            bad = 1;
            $display("FAIL [%s] %s bclk_out k=%0d: actual %0b expected %0b", ctx, tb_tag, k, bclk_out, exp_b);
        end
        if (frame_out !== exp_f) begin
            bad = 1;
            $display("FAIL [%s] R7 frame_out k=%0d: actual %0b expected %0b", ctx, k, frame_out, exp_f);
        end
        if (bit_clk !== exp_c) begin
            bad = 1;
            $display("FAIL [%s] %s bit_clk: actual %0b expected %0b", ctx, div_en ? "R3" : "R2", bit_clk, exp_c);
        end
        if (bad) miscompares++;
        if (bclk_out !== last_bclk) toggles++;
        last_bclk = bclk_out;
        if (frame_out) frames++;
    endtask

    task automatic tick(input bit r, input bit en, input bit msel, input bit p);
        rst = r; div_en = en; mode_sel = msel; frm_pulse = p;
        ext_bclk = gtick[1];
        gtick++;
        @(posedge clk);
        if (r) begin
            k = 0; ph = 0; pul = 0; m_mode = 0;
        end else if (!en) begin
            k = 0; ph = 0; pul = 0;
        end else if (p) begin
            k = 0; ph = 1; pul = 1; m_mode = msel;
        end else begin
            k++;
        end
        @(negedge clk);
        compare();
    endtask

    task automatic run(input int n, input bit en, input bit msel);
        for (int i = 0; i < n; i++) tick(0, en, msel, 0);
    endtask

    initial begin
        rst = 1; div_en = 0; mode_sel = 0; frm_pulse = 0; ext_bclk = 0;
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 3; i++) tick(1, 1, 1, 1);
        check(bclk_out == 0 && frame_out == 0, "R1 outputs low in reset", {bclk_out, frame_out}, 0);

        // R2: disabled, external clock passes, pulses ignored
        ctx = "R2 disabled";
        for (int i = 0; i < 20; i++) tick(0, 0, 1, (i % 5) == 0);
        check(bclk_out == 0 && frame_out == 0, "R2 pulses ignored while disabled", {bclk_out, frame_out}, 0);

        // R3/R4: divide-by-4 free run, then framed
        ctx = "R3 R4 integer ratio";
        run(40, 1, 0);
        tick(0, 1, 0, 1);
        check(bclk_out == 1 && frame_out == 1, "R6 realign on pulse", {bclk_out, frame_out}, 3);
        toggles = 0;
        run(IL - 1, 1, 0);
        tick(0, 1, 0, 1);
        check(toggles == 1024, "R4 flips per 4096-tick frame", toggles, 1024);

        // R8: ratio request alone does not switch
        ctx = "R8 mode hold";
        toggles = 0;
        run(100, 1, 1);
        check(toggles == 25, "R8 ratio unchanged before pulse", toggles, 25);

        // R5: fractional ratio
        ctx = "R5 fractional ratio";
        tick(0, 1, 1, 1);
        toggles = 0;
        run(FL - 1, 1, 1);
        tick(0, 1, 1, 1);
        check(toggles == 1024, "R5 flips per 4860-tick frame", toggles, 1024);
        toggles = 0;
        run(FL - 1, 1, 1);
        tick(0, 1, 1, 1);
        check(toggles == 1024, "R5 flips in second frame", toggles, 1024);

        // R7: free-running frame marker
        ctx = "R7 free run";
        frames = 0;
        run(2 * FL + 10, 1, 1);
        check(frames == 2, "R7 markers without pulses", frames, 2);

        // R6: early pulse
        ctx = "R6 early pulse";
        run(1000, 1, 1);
        tick(0, 1, 1, 1);
        check(bclk_out == 1 && frame_out == 1, "R6 off-schedule realign", {bclk_out, frame_out}, 3);
        run(50, 1, 1);

        // R9: disable and restart
        ctx = "R9 restart";
        for (int i = 0; i < 10; i++) tick(0, 0, 0, i[0]);
        tick(0, 1, 0, 0);
        check(bclk_out == 0 && frame_out == 0, "R9 cleared restart", {bclk_out, frame_out}, 0);
        toggles = 0;
        run(3, 1, 0);
        check(toggles == 0, "R9 no flip before 5 ticks", toggles, 0);
        run(1, 1, 0);
        check(toggles == 1, "R9 fractional ratio kept after restart", toggles, 1);
        run(200, 1, 0);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

endmodule